// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block holds the byte-wide configuration registers that sit behind a serial control port. The serial slave hands it one byte at a time: a write or a read strobe, a 13-bit byte address and the data byte. It also sends an end-of-transfer pulse when the chip select is released. Configuration bytes keep two copies. A serial write changes only the staging (buffer) copy. The active copy drives the parallel outputs to the rest of the device, and it loads the whole buffer in one clock only when an update has been requested and the transfer that requested it ends.

Two registers bypass the staging. The port configuration byte at address 0x000 controls how the serial slave shifts. It is applied the moment it is written, but only if its upper nibble is the bit reversal of its lower nibble. In that case it reads the same whether the slave shifts LSB or MSB first. A readback select byte at address 0x004 chooses whether reads of configuration bytes return the buffer or the active copy. The update request lives at address 0x232. The configuration bytes form a parameterised window, by default 16 bytes starting at 0x010. Every other address in the 13-bit space reads as zero and ignores writes.

Top module: `cfg_shadow_bank`

## Requirements
- R1: After reset, configuration byte k (address 0x010+k) holds 0x40+k in both copies. Address 0x000 reads 0x18, with LSB-first and unidirectional both off. Addresses 0x004 and 0x232 read 0x00, and rdata is 0x00.
- R2: A write to a configuration byte changes only the buffer copy. cfg_active, where byte k is bits 8k+7:8k, keeps its value.
- R3: A read that is strobed on one clock presents its byte on rdata after that clock edge. rdata holds the byte until the next read. For configuration bytes, bit 0 of register 0x004 selects the source: 0 returns the buffer copy and 1 returns the active copy. A write to 0x004 stores only bit 0, and it takes effect for the next read.
- R4: A write to 0x232 sets the update request to wdata bit 0, and the request reads back as bit 0 of 0x232. When the end-of-transfer pulse arrives while the request is set, every active byte loads its buffer byte on that clock.
- R5: The update request clears on the same clock edge that performs the copy. Reading 0x232 afterwards returns 0x00. An end-of-transfer pulse with no request pending leaves cfg_active unchanged.
- R6: A write to 0x000 whose bits 7:4 equal bits 0:3 in reversed order is accepted at once, with no update. lsb_first follows bit 1 and unidir follows bit 0. For example, 0x42 selects LSB-first and 0x81 selects unidirectional.
- R7: A write to 0x000 whose nibbles are not bit-mirrored (for example 0x02) is ignored: lsb_first, unidir and the readback of 0x000 are unchanged.
- R8: Bits 4 and 3 of 0x000 always read as 1, even after a mirrored write of 0x00.
- R9: Reads of any address other than 0x000, 0x004, 0x232 and the configuration window return 0x00. Writes to such addresses change no output and no readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 13 | Byte address from the serial slave |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| xfer_end | input | 1 | One-clock pulse when a serial transfer ends |
| rdata | output | 8 | Read data byte, registered |
| lsb_first | output | 1 | Serial slave shifts LSB first |
| unidir | output | 1 | Readback goes on the separate output pin |
| cfg_active | output | 128 | Active configuration bytes, byte k at bits 8k+7:8k |

## Verification
The bench stages writes and keeps cfg_active under watch until the committing transfer ends. A bank that leaked staged bytes early would show the new value before the end pulse. A bank that copied on a stray end pulse, or that forgot to clear the request, would show a second copy after a later unrequested pulse. Port-configuration writes are tried both mirrored and non-mirrored, and include 0x00, which must still read 0x18. An acceptance check that is off by one bit pair, or that lets long-instruction mode clear, changes lsb_first, unidir or the 0x000 readback. Reads are made with the readback select in both states, and at addresses just outside the window and far beyond 0x232. A select that is inverted, or an address decode that aliases, returns a wrong byte there.

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank #(
  parameter int ADDR_W   = 13,
  parameter int CFG_BASE = 16,
  parameter int CFG_N    = 16,
  parameter int SEL_ADDR = 4,
  parameter int UPD_ADDR = 562
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           wdata,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic                 xfer_end,
  output logic [7:0]           rdata,
  output logic                 lsb_first,
  output logic                 unidir,
  output logic [CFG_N*8-1:0]   cfg_active
);
  localparam int IDX_W = (CFG_N > 1) ? $clog2(CFG_N) : 1;
  localparam int CFG_END = CFG_BASE + CFG_N;
  localparam logic [7:0] PORT_FIXED = 8'h18;

  function automatic logic [7:0] rst_val(input int k);
    return 8'(64 + k);
  endfunction

  logic [7:0] port_q;
  logic       sel_q;
  logic       pend_q;
  logic [7:0] buf_q [CFG_N];
  logic [7:0] act_q [CFG_N];
  logic [7:0] rd_mux;

  wire hit_port = addr == '0;
  wire hit_sel  = addr == ADDR_W'(SEL_ADDR);
  wire hit_upd  = addr == ADDR_W'(UPD_ADDR);
  wire in_cfg   = (addr >= ADDR_W'(CFG_BASE)) && (addr < ADDR_W'(CFG_END));
  wire [IDX_W-1:0] idx = IDX_W'(addr - ADDR_W'(CFG_BASE));
  wire mirrored = wdata[7:4] == {wdata[0], wdata[1], wdata[2], wdata[3]};
  wire commit   = xfer_end && pend_q;

  assign lsb_first = port_q[1];
  assign unidir    = port_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_q <= PORT_FIXED;
      sel_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_en && hit_port && mirrored) port_q <= wdata | PORT_FIXED;
      if (wr_en && hit_sel) sel_q <= wdata[0];
      if (wr_en && hit_upd) pend_q <= wdata[0];
      else if (xfer_end)    pend_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < CFG_N; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        buf_q[g] <= rst_val(g);
        act_q[g] <= rst_val(g);
      end else begin
        if (wr_en && in_cfg && idx == IDX_W'(g)) buf_q[g] <= wdata;
        if (commit) act_q[g] <= buf_q[g];
      end
    end
    assign cfg_active[g*8 +: 8] = act_q[g];
  end

  always_comb begin
    rd_mux = '0;
    if (hit_port)     rd_mux = port_q | PORT_FIXED;
    else if (hit_sel) rd_mux = {7'b0, sel_q};
    else if (hit_upd) rd_mux = {7'b0, pend_q};
    else if (in_cfg)  rd_mux = sel_q ? act_q[idx] : buf_q[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R2
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_end && pend_q) |=> $stable(cfg_active));
  // R5
  upd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && pend_q && !(wr_en && hit_upd)) |=> !pend_q);
  // R7
  port_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit_port && mirrored) |=> ($stable(lsb_first) && $stable(unidir)));
  // R8
  long_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_q[4] && port_q[3]);
  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit_port && !hit_sel && !hit_upd && !in_cfg) |=> rdata == 8'h00);
endmodule

// File: tb/test_cfg_shadow_bank.sv
module test_cfg_shadow_bank;
  localparam int N = 16;
  localparam int BASE = 16;

  logic clk = 0, rst_n = 0;
  logic [12:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr_en = 0, rd_en = 0, xfer_end = 0;
  logic [7:0] rdata;
  logic lsb_first, unidir;
  logic [N*8-1:0] cfg_active;

  cfg_shadow_bank i_cfg_shadow_bank (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .xfer_end(xfer_end), .rdata(rdata),
    .lsb_first(lsb_first), .unidir(unidir), .cfg_active(cfg_active));

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  string cur_req = "R1";
  int m_buf[N], m_act[N];
  int m_port, m_sel, m_pend, m_rd;
  bit started = 0;

  function automatic bit is_mirror(int v);
    for (int i = 0; i < 4; i++)
      if (((v >> i) & 1) != ((v >> (7 - i)) & 1)) return 0;
    return 1;
  endfunction

  function automatic int model_read(int a);
    if (a == 0) return m_port | 'h18;
    if (a == 4) return m_sel;
    if (a == 'h232) return m_pend;
    if (a >= BASE && a < BASE + N) return m_sel ? m_act[a - BASE] : m_buf[a - BASE];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin m_buf[k] = 64 + k; m_act[k] = 64 + k; end
      m_port = 'h18; m_sel = 0; m_pend = 0; m_rd = 0;
    end else begin
      int a, d; bit c;
      a = int'(addr); d = int'(wdata);
      if (rd_en) m_rd = model_read(a);
      c = xfer_end && m_pend;
      if (c) for (int k = 0; k < N; k++) m_act[k] = m_buf[k];
      if (wr_en) begin
        if (a == 0 && is_mirror(d)) m_port = d | 'h18;
        else if (a == 4) m_sel = d & 1;
        else if (a >= BASE && a < BASE + N) m_buf[a - BASE] = d;
      end
      if (wr_en && a == 'h232) m_pend = d & 1;
      else if (xfer_end) m_pend = 0;
    end
  end

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    logic [N*8-1:0] exp_act;
    for (int k = 0; k < N; k++) exp_act[k*8 +: 8] = 8'(m_act[k]);
    chk(rdata == 8'(m_rd), "rdata", longint'(rdata), longint'(m_rd));
    chk(lsb_first == m_port[1], "lsb_first", longint'(lsb_first), longint'(m_port[1]));
    chk(unidir == m_port[0], "unidir", longint'(unidir), longint'(m_port[0]));
    chk(cfg_active == exp_act, "cfg_active", longint'(cfg_active[63:0]), longint'(exp_act[63:0]));
  end

  task automatic idle();
    @(negedge clk); wr_en = 0; rd_en = 0; xfer_end = 0;
  endtask
  task automatic wr(int a, int d);
    @(negedge clk); addr = 13'(a); wdata = 8'(d); wr_en = 1; rd_en = 0; xfer_end = 0;
    idle();
  endtask
  task automatic rd(int a);
    @(negedge clk); addr = 13'(a); rd_en = 1; wr_en = 0; xfer_end = 0;
    idle();
  endtask
  task automatic xend();
    @(negedge clk); xfer_end = 1; wr_en = 0; rd_en = 0;
    idle();
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; started = 1;
    cur_req = "R1";
    rd(0); rd(4); rd('h232); rd(BASE); rd(BASE + N - 1);
    cur_req = "R2";
    for (int k = 0; k < N; k++) wr(BASE + k, 'hC0 ^ k);
    rd(BASE + 3);
    cur_req = "R3";
    wr(4, 'hFF); rd(4); rd(BASE + 3); wr(4, 'h00); rd(BASE + 3);
    cur_req = "R5";
    xend(); rd(BASE + 5);
    cur_req = "R4";
    wr('h232, 1); rd('h232); wr(BASE + 2, 'h5A); xend();
    cur_req = "R5";
    rd('h232); xend(); wr(4, 1); rd(BASE + 2); rd(BASE + 7);
    cur_req = "R6";
    wr(0, 'h42); rd(0);
    cur_req = "R7";
    wr(0, 'h02); rd(0); wr(0, 'h24); rd(0);
    cur_req = "R6";
    wr(0, 'h81); rd(0);
    cur_req = "R8";
    wr(0, 'h00); rd(0); wr(0, 'hE7); rd(0);
    cur_req = "R9";
    wr(5, 'hFF); rd(5); rd(BASE - 1); rd(BASE + N); wr(BASE + N, 'h33);
    rd('h233); rd('h1FFF); rd('h100); wr('h1232, 1); xend(); rd(BASE);
    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      int a = (op < 5) ? BASE + int'($urandom_range(0, N - 1)) : int'($urandom_range(0, 7));
      if (op == 9) a = 'h232;
      if (op < 4) wr(a, int'($urandom_range(0, 255)));
      else if (op < 7) rd(a);
      else if (op == 7) xend();
      else wr(a, int'($urandom_range(0, 1)));
    end
    idle();
    started = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule